// File: doc/BRIEF.md
# Prescaled Core Tick Timer

The block is a periodic tick source that runs on the processor core clock. A prescaler of programmable width divides the core clock. Each prescaler tick steps a wide down counter by one. When the counter steps from one to zero, the block raises an interrupt for one cycle. It then either reloads the counter from a period register or parks at zero.

The core clock can run at full, half or quarter rate. The prescaler therefore scales its programmed divide ratio by the current clock-ratio select, so that ticks keep the same spacing in real time. Software programs the divide for full rate. At half rate the block uses half of that divide, and at quarter rate a quarter of it. A ratio change takes effect at once: the running prescaler count is compared against the new limit, so the tick that straddles the change is never stretched.

Top module: `core_tick_timer`

## Requirements
- R1: With a prescale value of 0, an enabled counter that is above 1 decreases by one on every clock.
- R2: At full rate (ratio code 0), a prescale value P gives one counter decrement every P+1 enabled clocks.
- R3: Ratio code 1 (half rate) divides by (P+1)/2, and ratio codes 2 and 3 (quarter rate) divide by (P+1)/4. Both results are floored, with a minimum divide of 1.
- R4: A ratio change is used from the next clock on. The prescaler tick falls on the first enabled clock on which the prescaler's count of enabled clocks since the last tick is at least the new divide minus one, so no tick interval grows beyond the old or the new divide.
- R5: A tick that finds the counter at 1 sets `irq` high for the following cycle. If auto-reload (control bit 1) is set, the same edge loads the counter from the period register.
- R6: Without auto-reload, the counter stays at 0 after expiry, and further ticks raise no interrupt.
- R7: A count write loads `wr_data` into the counter on the next edge. The write takes priority over a decrement on that edge and suppresses the interrupt that the decrement would have caused.
- R8: Clearing the enable (control bit 0) freezes both the prescaler and the counter. Setting it again resumes from the frozen phase.
- R9: After reset, the counter, period, prescale value, enable and auto-reload are all 0, and `irq` is low.
- R10: `wr_sel` selects the register written when `wr_en` is high: 0 is the prescale value (low 8 bits), 1 is the count, 2 is the period and 3 is the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| clk_ratio | input | 2 | Current core-clock ratio: 0 full, 1 half, 2/3 quarter |
| irq | output | 1 | One-cycle expiry pulse per expiry |
| count | output | 32 | Current counter value |

## Verification
A wrong prescaler phase appears on `count` within one divide interval: the next decrement lands one or more clocks away from the position the requirements predict. A wrong reload or expiry decision shows up on `irq` and `count` at the very edge where the counter leaves 1. The bench steps a requirement-level model next to the design and compares both outputs on every clock. This covers ratio changes made in the middle of an interval and enable gaps.

// File: rtl/core_tick_timer.sv
module core_tick_timer #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       clk_ratio,
  output logic             irq,
  output logic [CNT_W-1:0] count
);
  localparam logic [1:0] SEL_PRE = 2'd0;
  localparam logic [1:0] SEL_CNT = 2'd1;
  localparam logic [1:0] SEL_PER = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  logic [PRE_W-1:0] pre_q, pcnt_q, eff;
  logic [CNT_W-1:0] cnt_q, per_q;
  logic             en_q, auto_q, irq_q;
  logic [1:0]       shift;
  logic [PRE_W:0]   div_full, div_scaled;
  logic             tick, cnt_wr;

  assign shift      = clk_ratio[1] ? 2'd2 : {1'b0, clk_ratio[0]};
  assign div_full   = {1'b0, pre_q} + 1'b1;
  assign div_scaled = div_full >> shift;
  assign eff        = (div_scaled == '0) ? '0 : PRE_W'(div_scaled - 1'b1);
  assign tick       = en_q && (pcnt_q >= eff);
  assign cnt_wr     = wr_en && (wr_sel == SEL_CNT);
  assign irq        = irq_q;
  assign count      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      per_q  <= '0;
      en_q   <= 1'b0;
      auto_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PRE: pre_q <= wr_data[PRE_W-1:0];
        SEL_PER: per_q <= wr_data;
        SEL_CTL: begin
          en_q   <= wr_data[0];
          auto_q <= wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (en_q) pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (cnt_wr) begin
      cnt_q <= wr_data;
      irq_q <= 1'b0;
    end else if (tick && cnt_q == CNT_W'(1)) begin
      cnt_q <= auto_q ? per_q : '0;
      irq_q <= 1'b1;
    end else begin
      irq_q <= 1'b0;
      if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r5_irq_after_one: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cnt_q) == CNT_W'(1)) && $past(tick));

  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt_q == ($past(auto_q) ? $past(per_q) : '0));

  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_wr) |=> ($stable(cnt_q) && $stable(pcnt_q) && !irq));

  a_r6_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !cnt_wr) |=> (cnt_q == '0 && !irq));

  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_data) && !irq));

  a_r1_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q > CNT_W'(1) && !cnt_wr) |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pcnt_q == '0);
endmodule

// File: tb/core_tick_timer_test.sv
module core_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  clk_ratio = 2'd0;
  logic        irq;
  logic [31:0] count;

  core_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .clk_ratio(clk_ratio), .irq(irq), .count(count)
  );

  always #4 clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] cnt;
    logic        irq;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_cnt = '0, m_per = '0;
  logic [7:0]  m_pre = '0;
  int          m_ph = 0;
  logic        m_en = 0, m_auto = 0, m_irq = 0;
  logic [1:0]  m_ratio = 2'd0;

  function automatic int m_eff();
    int sh, dv;
    sh = m_ratio[1] ? 2 : int'(m_ratio[0]);
    dv = (int'(m_pre) + 1) >> sh;
    return (dv == 0) ? 0 : dv - 1;
  endfunction

  function automatic void model_edge();
    bit t;
    m_irq = 0;
    if (m_en) begin
      t = (m_ph >= m_eff());
      m_ph = t ? 0 : m_ph + 1;
      if (t) begin
        if (m_cnt == 32'd1) begin
          m_irq = 1;
          m_cnt = m_auto ? m_per : '0;
        end else if (m_cnt != '0) m_cnt = m_cnt - 1;
      end
    end
  endfunction

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (count !== e.cnt || irq !== e.irq) begin
        fails++;
        $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                 e.tag, count, irq, e.cnt, e.irq);
      end
    end
  end

  task automatic push(string tag);
    exp_q.push_back('{tag, m_cnt, m_irq});
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cycles(int n, string tag);
    for (int i = 0; i < n; i++) begin
      step();
      model_edge();
      push(tag);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d, string tag);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
    model_edge();
    case (sel)
      2'd0: m_pre = d[7:0];
      2'd1: begin m_cnt = d; m_irq = 0; end
      2'd2: m_per = d;
      default: begin m_en = d[0]; m_auto = d[1]; end
    endcase
    push(tag);
  endtask

  task automatic set_ratio(logic [1:0] r);
    clk_ratio = r;
    m_ratio = r;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push("R9 reset state");

    wr(2'd1, 32'd5, "R10 count select");
    wr(2'd3, 32'd1, "R10 control select");
    cycles(6, "R1 every-clock decrement");
    cycles(3, "R6 parked at zero");

    wr(2'd1, 32'd7, "R7 load while enabled");
    cycles(6, "R7 after load");
    wr(2'd1, 32'd3, "R7 write beats expiry");
    cycles(5, "R6 second expiry");

    wr(2'd3, 32'd0, "R8 disable");
    wr(2'd0, 32'd3, "R10 prescale select");
    wr(2'd2, 32'd3, "R10 period select");
    wr(2'd1, 32'd2, "R10 count reload");
    wr(2'd3, 32'd3, "R5 enable with reload");
    cycles(26, "R2 divide by four");
    cycles(4, "R5 reload train");

    wr(2'd3, 32'd2, "R8 freeze");
    cycles(5, "R8 frozen");
    wr(2'd3, 32'd3, "R8 resume");
    cycles(9, "R8 resumed phase");

    set_ratio(2'd1);
    cycles(12, "R3 half rate");
    set_ratio(2'd2);
    cycles(8, "R3 quarter rate");
    set_ratio(2'd3);
    cycles(4, "R3 quarter code 3");
    set_ratio(2'd0);
    cycles(12, "R4 back to full");

    wr(2'd2, 32'd2, "R5 short period");
    wr(2'd0, 32'd15, "R2 prescale 15");
    cycles(11, "R2 long divide");
    set_ratio(2'd2);
    cycles(14, "R4 clamp to quarter");
    set_ratio(2'd1);
    cycles(3, "R4 half after quarter");
    set_ratio(2'd0);
    cycles(20, "R4 full again");

    wr(2'd0, 32'd1, "R3 small prescale");
    set_ratio(2'd2);
    cycles(6, "R3 divide floor of one");

    step();
    step();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule